// File: doc/BRIEF.md
# Interrupt Routing and Conversion Pacer Control

This block holds the one-byte control word of a data-acquisition front end and does the small amount of logic that hangs off it. A pending-interrupt latch is armed by the control word and set by one of three analog events: conversion done, FIFO half-full or end of burst. A two-bit source field, supplied by a neighbouring register, picks the event. A separate clear strobe drops the latch. The pending request can be joined by an external interrupt input. The combined request is then steered onto one of sixteen host IRQ lines by a 3-bit level code, and the code-to-line table depends on whether the block runs in compatible or enhanced mode.

The same control word also picks what starts a conversion: a software strobe, the internal pacer tick, or a rising or falling edge on an asynchronous external trigger. Each selected event produces a one-clock convert pulse. Bit 2 of the word is a DMA enable in compatible mode and a burst enable in enhanced mode. A second burst-enable input is ORed into the burst output.

There are two small state machines. The latch machine has the states LATCH_IDLE and LATCH_PEND. It goes from LATCH_IDLE to LATCH_PEND on a qualified event, and from LATCH_PEND back to LATCH_IDLE on a clear strobe that arrives with no event in the same cycle. The trigger machine has the states TRIG_LOW and TRIG_HIGH and follows the synchronised trigger. Its TRIG_LOW to TRIG_HIGH transition is a rising edge, and its TRIG_HIGH to TRIG_LOW transition is a falling edge.

Top module: `irq_pacer_ctl`

## Requirements
- R1: The control word is written from `cfg_wdata` on a cycle with `cfg_we` high and reads back unchanged on `cfg_rdata` from the next cycle. Its fields are: bits 1:0 pacer select, bit 2 mode bit, bit 3 external interrupt enable, bits 6:4 level code {b6,b5,b4}, bit 7 master interrupt enable.
- R2: While the master enable (bit 7) is 0, no event sets the latch and `irq_out` stays all zeros.
- R3: `ai_src` selects the latch event: 00 conversion done, 01 FIFO half-full, 10 end of burst, 11 no event. An unselected event does not set the latch.
- R4: Once set, the latch holds until a clear strobe. If `clr_stb` and a selected event occur in the same cycle, the latch stays set. The clear strobe has the same effect in both modes.
- R5: In enhanced mode (`enh_mode`=1), level codes 0..7 map to: none, IRQ11, IRQ2, IRQ3, IRQ10, IRQ5, IRQ15, IRQ7.
- R6: In compatible mode, level codes 0..7 map to: none, none, IRQ2, IRQ3, none, IRQ5, IRQ6, IRQ7. IRQ4, IRQ10, IRQ11 and IRQ15 are never driven in this mode.
- R7: A high `ext_irq_in` drives the same IRQ line as the analog path one cycle later. This happens only when enhanced mode, the external enable (bit 3) and the master enable are all 1.
- R8: `irq_out` is a registered vector with at most one bit set. It becomes nonzero one cycle after the latch sets, two clock edges after the event is sampled.
- R9: Pacer select encoding is 00 software strobe, 01 external falling edge, 10 external rising edge, 11 internal tick. Each selected event gives exactly one `conv_pulse`, and unselected events give none. For the software strobe and the tick, the pulse appears one edge after the input is sampled.
- R10: The external trigger passes through two synchronising flops. A rising edge that is sampled at one edge yields `conv_pulse` after the third edge, and the pulse lasts one cycle.
- R11: `dma_en` equals bit 2 in compatible mode and is 0 in enhanced mode. `burst_en` equals (bit 2 AND enhanced mode) OR `alt_burst_en`.
- R12: Reset (`rst_n` low, asynchronous) clears the control word, the latch, `irq_out` and `conv_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word read data |
| clr_stb | input | 1 | Clear strobe for the pending latch |
| enh_mode | input | 1 | 1 = enhanced mode, 0 = compatible mode |
| ai_src | input | 2 | Analog interrupt event select |
| ev_conv_done | input | 1 | Single conversion done event |
| ev_fifo_half | input | 1 | FIFO half-full event |
| ev_burst_end | input | 1 | End of burst event |
| ext_irq_in | input | 1 | External interrupt request |
| alt_burst_en | input | 1 | Alternate burst enable |
| sw_conv | input | 1 | Software convert strobe |
| pacer_tick | input | 1 | Internal pacer tick |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_pulse | output | 1 | One-clock convert start |
| dma_en | output | 1 | DMA enable (compatible mode) |
| burst_en | output | 1 | Burst enable |
| irq_out | output | 16 | One-hot host IRQ lines |

## Verification
The bench builds the block with its defaults: sixteen IRQ lines, three analog events and a two-stage synchroniser. At these values every level code can be swept in both modes and checked against all sixteen lines, and every source select can be crossed with every event. The four pacer selects are crossed with the four start stimuli, which covers both external edge directions through the real synchroniser depth.

// File: rtl/irq_pacer_pkg.sv
`timescale 1ns/1ps
package irq_pacer_pkg;

    localparam int CFG_W    = 8;
    localparam int LINE_W   = 4;

    typedef enum logic [1:0] {
        PACE_SOFT     = 2'b00,
        PACE_EXT_FALL = 2'b01,
        PACE_EXT_RISE = 2'b10,
        PACE_TIMER    = 2'b11
    } pace_src_e;

    typedef struct packed {
        logic       irq_en;
        logic [2:0] level;
        logic       ext_en;
        logic       mode_bit;
        logic [1:0] pace;
    } ctl_word_t;

    typedef enum logic {
        LATCH_IDLE,
        LATCH_PEND
    } latch_state_e;

    typedef enum logic {
        TRIG_LOW,
        TRIG_HIGH
    } trig_state_e;

    typedef struct packed {
        logic              hit;
        logic [LINE_W-1:0] line;
    } irq_route_t;

    function automatic irq_route_t route_level(input logic [2:0] code, input logic enh);
        irq_route_t r;
        r = '0;
        if (enh) begin
            unique case (code)
                3'd0: r = '{hit: 1'b0, line: 4'd0};
                3'd1: r = '{hit: 1'b1, line: 4'd11};
                3'd2: r = '{hit: 1'b1, line: 4'd2};
                3'd3: r = '{hit: 1'b1, line: 4'd3};
                3'd4: r = '{hit: 1'b1, line: 4'd10};
                3'd5: r = '{hit: 1'b1, line: 4'd5};
                3'd6: r = '{hit: 1'b1, line: 4'd15};
                3'd7: r = '{hit: 1'b1, line: 4'd7};
            endcase
        end else begin
            unique case (code)
                3'd0: r = '{hit: 1'b0, line: 4'd0};
                3'd1: r = '{hit: 1'b0, line: 4'd0};
                3'd2: r = '{hit: 1'b1, line: 4'd2};
                3'd3: r = '{hit: 1'b1, line: 4'd3};
                3'd4: r = '{hit: 1'b0, line: 4'd0};
                3'd5: r = '{hit: 1'b1, line: 4'd5};
                3'd6: r = '{hit: 1'b1, line: 4'd6};
                3'd7: r = '{hit: 1'b1, line: 4'd7};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch
    import irq_pacer_pkg::*;
#(
    parameter int N_EV  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EV-1:0]  ev,
    input  logic [SEL_W-1:0] sel,
    input  logic             arm,
    input  logic             clr,
    output logic             pend,
    output logic             set_hit
);

    latch_state_e state_q, state_d;
    logic         ev_hit;

    always_comb begin
        ev_hit = 1'b0;
        for (int i = 0; i < N_EV; i++) begin
            if (sel == SEL_W'(i) && ev[i]) ev_hit = 1'b1;
        end
    end

    assign set_hit = arm & ev_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_IDLE: if (set_hit)         state_d = LATCH_PEND;
            LATCH_PEND: if (clr && !set_hit) state_d = LATCH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == LATCH_PEND);
    end

endmodule

// File: rtl/irq_level_map.sv
`timescale 1ns/1ps
module irq_level_map
    import irq_pacer_pkg::*;
#(
    parameter int IRQ_LINES = 16
) (
    input  logic                 req,
    input  logic [2:0]           level,
    input  logic                 enh,
    output logic [IRQ_LINES-1:0] lines
);

    irq_route_t rt;

    assign rt = route_level(level, enh);

    for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
        assign lines[i] = req & rt.hit & (32'(rt.line) == i);
    end

endmodule

// File: rtl/pacer_trig.sv
`timescale 1ns/1ps
module pacer_trig
    import irq_pacer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] pace_sel,
    input  logic       sw_conv,
    input  logic       tick,
    output logic       conv_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   trig_s;
    trig_state_e            state_q, state_d;
    logic                   rise, fall, start;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else if (s == 0) sync_q[s] <= trig_in;
            else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end

    assign trig_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            TRIG_LOW:  if (trig_s)  begin state_d = TRIG_HIGH; rise = 1'b1; end
            TRIG_HIGH: if (!trig_s) begin state_d = TRIG_LOW;  fall = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (pace_src_e'(pace_sel))
            PACE_SOFT:     start = sw_conv;
            PACE_EXT_FALL: start = fall;
            PACE_EXT_RISE: start = rise;
            PACE_TIMER:    start = tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_pulse <= 1'b0;
        else        conv_pulse <= start;
    end

endmodule

// File: rtl/irq_pacer_ctl.sv
`timescale 1ns/1ps
module irq_pacer_ctl
    import irq_pacer_pkg::*;
#(
    parameter int IRQ_LINES   = 16,
    parameter int N_EV        = 3,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_EV + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 clr_stb,
    input  logic                 enh_mode,
    input  logic [SEL_W-1:0]     ai_src,
    input  logic                 ev_conv_done,
    input  logic                 ev_fifo_half,
    input  logic                 ev_burst_end,
    input  logic                 ext_irq_in,
    input  logic                 alt_burst_en,
    input  logic                 sw_conv,
    input  logic                 pacer_tick,
    input  logic                 ext_trig,
    output logic                 conv_pulse,
    output logic                 dma_en,
    output logic                 burst_en,
    output logic [IRQ_LINES-1:0] irq_out
);

    ctl_word_t            ctl_q;
    logic                 latch_pend;
    logic                 latch_set;
    logic                 ext_ok;
    logic                 req;
    logic [IRQ_LINES-1:0] lines_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (cfg_we) ctl_q <= ctl_word_t'(cfg_wdata);
    end

    assign cfg_rdata = ctl_q;

    irq_src_latch #(.N_EV(N_EV), .SEL_W(SEL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      ({ev_burst_end, ev_fifo_half, ev_conv_done}),
        .sel     (ai_src),
        .arm     (ctl_q.irq_en),
        .clr     (clr_stb),
        .pend    (latch_pend),
        .set_hit (latch_set)
    );

    assign ext_ok = enh_mode & ctl_q.ext_en & ext_irq_in;
    assign req    = ctl_q.irq_en & (latch_pend | ext_ok);

    irq_level_map #(.IRQ_LINES(IRQ_LINES)) u_map (
        .req   (req),
        .level (ctl_q.level),
        .enh   (enh_mode),
        .lines (lines_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= lines_d;
    end

    pacer_trig #(.SYNC_STAGES(SYNC_STAGES)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (ext_trig),
        .pace_sel   (ctl_q.pace),
        .sw_conv    (sw_conv),
        .tick       (pacer_tick),
        .conv_pulse (conv_pulse)
    );

    assign dma_en   = ~enh_mode & ctl_q.mode_bit;
    assign burst_en = (enh_mode & ctl_q.mode_bit) | alt_burst_en;

endmodule

// File: rtl/irq_pacer_chk.sv
`timescale 1ns/1ps
module irq_pacer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cfg_rdata,
    input logic        enh_mode,
    input logic        sw_conv,
    input logic        clr_stb,
    input logic [15:0] irq_out,
    input logic        conv_pulse,
    input logic        latch_pend,
    input logic        latch_set
);

    assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != 16'h0) |-> $past(cfg_rdata[7]));

    assert_irq_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));

    assert_compat_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enh_mode) |-> (irq_out[4] | irq_out[10] | irq_out[11] | irq_out[15]) == 1'b0);

    assert_soft_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_pulse && $past(cfg_rdata[1:0]) == 2'b00) |-> $past(sw_conv));

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !latch_set) |=> !latch_pend);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_set |=> latch_pend);

endmodule

bind irq_pacer_ctl irq_pacer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .enh_mode   (enh_mode),
    .sw_conv    (sw_conv),
    .clr_stb    (clr_stb),
    .irq_out    (irq_out),
    .conv_pulse (conv_pulse),
    .latch_pend (latch_pend),
    .latch_set  (latch_set)
);

// File: tb/test_irq_pacer_ctl.sv
`timescale 1ns/1ps
module test_irq_pacer_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        clr_stb;
    logic        enh_mode;
    logic [1:0]  ai_src;
    logic        ev_conv_done, ev_fifo_half, ev_burst_end;
    logic        ext_irq_in, alt_burst_en, sw_conv, pacer_tick, ext_trig;
    logic        conv_pulse, dma_en, burst_en;
    logic [15:0] irq_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_pacer_ctl i_irq_pacer_ctl (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_latch();
        clr_stb = 1'b1;
        tick();
        clr_stb = 1'b0;
        tick();
    endtask

    task automatic fire(int e);
        case (e)
            0: ev_conv_done = 1'b1;
            1: ev_fifo_half = 1'b1;
            default: ev_burst_end = 1'b1;
        endcase
        tick();
        {ev_conv_done, ev_fifo_half, ev_burst_end} = 3'b000;
        tick();
    endtask

    function automatic logic [31:0] exp_vec(int enh, int code);
        int ln;
        if (enh != 0) begin
            case (code)
                1: ln = 11; 2: ln = 2; 3: ln = 3; 4: ln = 10;
                5: ln = 5; 6: ln = 15; 7: ln = 7; default: ln = -1;
            endcase
        end else begin
            case (code)
                2: ln = 2; 3: ln = 3; 5: ln = 5; 6: ln = 6;
                7: ln = 7; default: ln = -1;
            endcase
        end
        return (ln < 0) ? 32'h0 : (32'h1 << ln);
    endfunction

    task automatic pace(int ps, int st);
        int n;
        if (st == 1) begin ext_trig = 1'b1; repeat (4) tick(); end
        if (st == 2) begin ext_trig = 1'b0; repeat (4) tick(); end
        n = 0;
        case (st)
            0: sw_conv = 1'b1;
            1: ext_trig = 1'b0;
            2: ext_trig = 1'b1;
            default: pacer_tick = 1'b1;
        endcase
        tick();
        n += int'(conv_pulse);
        sw_conv = 1'b0; pacer_tick = 1'b0;
        repeat (5) begin tick(); n += int'(conv_pulse); end
        ext_trig = 1'b0;
        repeat (4) tick();
        chk($sformatf("R9 pacer sel=%0d stim=%0d", ps, st), 32'(n), (ps == st) ? 32'd1 : 32'd0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h0; clr_stb = 1'b0; enh_mode = 1'b0;
        ai_src = 2'b00; ev_conv_done = 1'b0; ev_fifo_half = 1'b0; ev_burst_end = 1'b0;
        ext_irq_in = 1'b0; alt_burst_en = 1'b0; sw_conv = 1'b0; pacer_tick = 1'b0; ext_trig = 1'b0;
        repeat (3) tick();
        chk("R12 reset word", 32'(cfg_rdata), 32'h0);
        chk("R12 reset irq", 32'(irq_out), 32'h0);
        chk("R12 reset conv", 32'(conv_pulse), 32'h0);
        rst_n = 1'b1;
        tick();

        wr(8'hA5); chk("R1 readback A5", 32'(cfg_rdata), 32'hA5);
        wr(8'h5A); chk("R1 readback 5A", 32'(cfg_rdata), 32'h5A);

        for (int m = 0; m < 2; m++) begin
            enh_mode = m[0];
            for (int c = 0; c < 8; c++) begin
                clear_latch();
                wr({1'b1, c[2:0], 4'b0000});
                ai_src = 2'b00;
                fire(0);
                chk($sformatf("%s map code=%0d", (m != 0) ? "R5" : "R6", c),
                    32'(irq_out), exp_vec(m, c));
            end
        end

        enh_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 3; e++) begin
                clear_latch();
                wr(8'hF0);
                ai_src = s[1:0];
                fire(e);
                chk($sformatf("R3 src=%0d ev=%0d", s, e), 32'(irq_out), (s == e) ? 32'h80 : 32'h0);
            end
        end
        ai_src = 2'b00;

        clear_latch();
        fire(0);
        repeat (5) tick();
        chk("R4 latch holds", 32'(irq_out), 32'h80);
        clear_latch();
        chk("R4 clear drops", 32'(irq_out), 32'h0);
        enh_mode = 1'b0;
        fire(0);
        clear_latch();
        chk("R4 clear compat", 32'(irq_out), 32'h0);
        enh_mode = 1'b1;
        ev_conv_done = 1'b1; clr_stb = 1'b1;
        tick();
        ev_conv_done = 1'b0; clr_stb = 1'b0;
        tick();
        chk("R4 set wins", 32'(irq_out), 32'h80);

        clear_latch();
        ev_conv_done = 1'b1;
        tick();
        ev_conv_done = 1'b0;
        chk("R8 not yet", 32'(irq_out), 32'h0);
        tick();
        chk("R8 one cycle after latch", 32'(irq_out), 32'h80);

        clear_latch();
        wr(8'h70);
        fire(0);
        chk("R2 disabled no irq", 32'(irq_out), 32'h0);
        wr(8'hF0);
        tick();
        chk("R2 latch not armed", 32'(irq_out), 32'h0);

        clear_latch();
        wr(8'hF8);
        ext_irq_in = 1'b1; tick();
        chk("R7 ext enhanced", 32'(irq_out), 32'h80);
        ext_irq_in = 1'b0; tick();
        chk("R7 ext released", 32'(irq_out), 32'h0);
        enh_mode = 1'b0; ext_irq_in = 1'b1; tick();
        chk("R7 ext compat ignored", 32'(irq_out), 32'h0);
        enh_mode = 1'b1; wr(8'hF0); tick();
        chk("R7 ext enable off", 32'(irq_out), 32'h0);
        wr(8'h78); tick();
        chk("R7 master off", 32'(irq_out), 32'h0);
        wr(8'hE8); tick();
        chk("R7 shared level 15", 32'(irq_out), 32'h8000);
        ext_irq_in = 1'b0;
        tick();

        enh_mode = 1'b0; wr(8'h04);
        chk("R11 dma compat", 32'(dma_en), 32'h1);
        chk("R11 burst compat", 32'(burst_en), 32'h0);
        enh_mode = 1'b1; #0.5;
        chk("R11 dma enhanced", 32'(dma_en), 32'h0);
        chk("R11 burst enhanced", 32'(burst_en), 32'h1);
        wr(8'h00); alt_burst_en = 1'b1; #0.5;
        chk("R11 alt burst", 32'(burst_en), 32'h1);
        alt_burst_en = 1'b0; #0.5;
        chk("R11 burst off", 32'(burst_en), 32'h0);

        for (int ps = 0; ps < 4; ps++) begin
            wr(ps[7:0]);
            for (int st = 0; st < 4; st++) pace(ps, st);
        end

        wr(8'h00);
        sw_conv = 1'b1; tick(); sw_conv = 1'b0;
        chk("R9 soft latency", 32'(conv_pulse), 32'h1);
        tick();
        chk("R9 soft single", 32'(conv_pulse), 32'h0);

        wr(8'h02);
        ext_trig = 1'b1;
        tick(); chk("R10 edge1", 32'(conv_pulse), 32'h0);
        tick(); chk("R10 edge2", 32'(conv_pulse), 32'h0);
        tick(); chk("R10 edge3", 32'(conv_pulse), 32'h1);
        tick(); chk("R10 single", 32'(conv_pulse), 32'h0);
        ext_trig = 1'b0;
        repeat (4) tick();

        clear_latch();
        wr(8'hF0);
        fire(0);
        chk("R12 pre reset irq", 32'(irq_out), 32'h80);
        rst_n = 1'b0; #1;
        chk("R12 word cleared", 32'(cfg_rdata), 32'h0);
        chk("R12 irq cleared", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        tick();
        wr(8'hF0);
        tick();
        chk("R12 latch cleared", 32'(irq_out), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule